// File: doc/BRIEF.md
# Spread-Spectrum Sweep Offset Generator

This block produces a signed frequency-offset word, in parts per million of the nominal output frequency. The word drives a fractional-N feedback divider so that the synthesized clock moves slowly up and down in frequency and its radiated energy is spread over a band. Each pulse on the `step` input moves the sweep one point along a symmetric triangle. The new offset appears on `offset_ppm`, and `offset_vld` is high for that one clock.

A two-bit select picks the profile:

- One code gives a 0.9 % spread centred on the nominal frequency.
- Two codes give down spreads, 1 % and 0.5 %, that never rise above nominal.
- The fourth code disables spreading.

The active-low `spread_n` input gates spreading as a whole. The same profiles serve any nominal frequency, because the word is relative. A profile change requested in mid-sweep waits until the sweep is back at the nominal point, so the offset never jumps.

Top module: `ssc_profile_gen`

## Requirements
- R1: While `rst` is high, and on the clock after it is released, `offset_ppm` is 0 and `offset_vld` is 0.
- R2: A strobe taken while `spread_n` is 1 produces offset 0 and ends any sweep in progress. It does so at once, even in mid-sweep.
- R3: With select code 01 (centre spread) the offset is 4500 - (9000*p)/STEPS, using truncating division, for a sweep position p in 0..STEPS. The offset therefore spans +4500 to -4500 ppm.
- R4: With select code 10 (1 % down spread) the offset is -(10000*p)/STEPS. It reaches -10000 ppm and is never above 0.
- R5: With select code 11 (0.5 % down spread) the offset is -(5000*p)/STEPS. It spans 0 to -5000 ppm.
- R6: With select code 00, a strobe taken while no sweep is running produces offset 0, and no sweep starts.
- R7: While a sweep runs, each strobe moves p by exactly one. The direction reverses exactly at p = STEPS and at p = 0.
- R8: The first strobe with `spread_n` at 0 and a non-zero select starts a sweep at the nominal point and outputs 0. The nominal point is p = STEPS/2 for the centre profile and p = 0 for the down profiles. The next strobe moves toward lower frequency, with p increasing.
- R9: If the select differs from the running profile, the change is applied only on the strobe that brings the sweep back to the nominal point. That strobe outputs 0 and restarts as in R8 with the new profile. If the new code is 00, spreading stops there instead.
- R10: `offset_vld` is high for exactly the one clock after each strobe and at no other time. `offset_ppm` changes only in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spread_n | input | 1 | Spread enable, active low |
| mode_sel | input | 2 | Profile select: 00 none, 01 centre 0.9 %, 10 down 1 %, 11 down 0.5 % |
| step | input | 1 | Strobe that advances the sweep by one point |
| offset_ppm | output | OFS_W | Signed offset from nominal, in ppm |
| offset_vld | output | 1 | One-clock pulse marking a new offset |

## Verification
A pending profile change and the return of the sweep to the nominal point can fall on the same strobe. That strobe must output zero and restart the position of the new profile.

The bench provokes this by changing the select in mid-sweep and then keeping up the strobes through the crossing. A scoreboard model predicts every word, so an early switch, a late switch or a wrong restart position shows up as a mismatch on the first step after the crossing.

A second collision is a disable that lands on a turnaround strobe. The bench judges it the same way, expecting zero on that word and a fresh start afterwards.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        SPR_NONE  = 2'b00,
        SPR_CTR09 = 2'b01,
        SPR_DN10  = 2'b10,
        SPR_DN05  = 2'b11
    } spr_mode_e;

    localparam int PPM_CTR_TOP  = 4500;
    localparam int PPM_CTR_SPAN = 9000;
    localparam int PPM_DN10     = 10000;
    localparam int PPM_DN05     = 5000;

    typedef struct packed {
        logic signed [31:0] top_ppm;
        logic signed [31:0] span_ppm;
    } prof_t;

    function automatic prof_t prof_of(spr_mode_e m);
        prof_t r;
        case (m)
            SPR_CTR09: begin r.top_ppm = PPM_CTR_TOP; r.span_ppm = PPM_CTR_SPAN; end
            SPR_DN10:  begin r.top_ppm = 0;           r.span_ppm = PPM_DN10;     end
            SPR_DN05:  begin r.top_ppm = 0;           r.span_ppm = PPM_DN05;     end
            default:   begin r.top_ppm = 0;           r.span_ppm = 0;            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ssc_mode_decode.sv
module ssc_mode_decode
    import ssc_pkg::*;
#(
    parameter int STEPS = 64,
    localparam int POS_W = $clog2(STEPS + 1)
) (
    input  logic [1:0]       code,
    output spr_mode_e        mode,
    output logic [POS_W-1:0] home_pos
);
    localparam logic [POS_W-1:0] HALF = POS_W'(STEPS / 2);

    always_comb begin
        mode     = spr_mode_e'(code);
        home_pos = (mode == SPR_CTR09) ? HALF : '0;
    end
endmodule

// File: rtl/ssc_sweep_fsm.sv
module ssc_sweep_fsm
    import ssc_pkg::*;
#(
    parameter int STEPS = 64,
    localparam int POS_W = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             spread_n,
    input  spr_mode_e        sel_mode,
    input  logic [POS_W-1:0] sel_home,
    input  logic [POS_W-1:0] cur_home,
    output logic             cur_active,
    output spr_mode_e        cur_mode,
    output logic             nxt_active,
    output spr_mode_e        nxt_mode,
    output logic [POS_W-1:0] nxt_pos
);
    localparam logic [POS_W-1:0] LIM = POS_W'(STEPS);

    typedef struct packed {
        logic             active;
        spr_mode_e        mode;
        logic [POS_W-1:0] pos;
        logic             dn;
    } sweep_t;

    sweep_t cur, nxt;
    logic [POS_W-1:0] adv_pos;
    logic             adv_dn;

    // one position move along the triangle, turning exactly at the limits
    always_comb begin
        if (cur.dn) begin
            adv_pos = cur.pos + 1'b1;
            adv_dn  = (adv_pos != LIM);
        end else begin
            adv_pos = cur.pos - 1'b1;
            adv_dn  = (adv_pos == '0);
        end
    end

    always_comb begin
        nxt = cur;
        if (step) begin
            if (spread_n) begin
                nxt.active = 1'b0;
            end else if (!cur.active) begin
                if (sel_mode != SPR_NONE) begin
                    nxt.active = 1'b1;
                    nxt.mode   = sel_mode;
                    nxt.pos    = sel_home;
                    nxt.dn     = 1'b1;
                end
            end else begin
                nxt.pos = adv_pos;
                nxt.dn  = adv_dn;
                // deferred profile change lands only on the nominal point
                if (adv_pos == cur_home && sel_mode != cur.mode) begin
                    if (sel_mode == SPR_NONE) begin
                        nxt.active = 1'b0;
                    end else begin
                        nxt.mode = sel_mode;
                        nxt.pos  = sel_home;
                        nxt.dn   = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{active: 1'b0, mode: SPR_NONE, pos: '0, dn: 1'b1};
        end else begin
            cur <= nxt;
        end
    end

    assign cur_active = cur.active;
    assign cur_mode   = cur.mode;
    assign nxt_active = nxt.active;
    assign nxt_mode   = nxt.mode;
    assign nxt_pos    = nxt.pos;
endmodule

// File: rtl/ssc_offset_map.sv
module ssc_offset_map
    import ssc_pkg::*;
#(
    parameter int STEPS = 64,
    parameter int OFS_W = 16,
    localparam int POS_W = $clog2(STEPS + 1)
) (
    input  logic                    active,
    input  spr_mode_e               mode,
    input  logic [POS_W-1:0]        pos,
    output logic signed [OFS_W-1:0] ofs
);
    prof_t              prof;
    logic signed [31:0] prod;
    logic signed [31:0] val;

    always_comb begin
        prof = prof_of(mode);
        prod = prof.span_ppm * $signed({{(32 - POS_W){1'b0}}, pos});
        val  = active ? (prof.top_ppm - prod / STEPS) : 32'sd0;
        ofs  = val[OFS_W-1:0];
    end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int STEPS = 64,
    parameter int OFS_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spread_n,
    input  logic [1:0]              mode_sel,
    input  logic                    step,
    output logic signed [OFS_W-1:0] offset_ppm,
    output logic                    offset_vld
);
    localparam int POS_W = $clog2(STEPS + 1);

    spr_mode_e        sel_mode, cur_mode, nxt_mode, cur_mode_dec;
    logic [POS_W-1:0] sel_home, cur_home, nxt_pos;
    logic             cur_active, nxt_active;
    logic [1:0]       cur_mode_bits;
    logic signed [OFS_W-1:0] nxt_ofs;

    ssc_mode_decode #(.STEPS(STEPS)) u_dec_sel (
        .code(mode_sel), .mode(sel_mode), .home_pos(sel_home)
    );

    assign cur_mode_bits = cur_mode;

    ssc_mode_decode #(.STEPS(STEPS)) u_dec_cur (
        .code(cur_mode_bits), .mode(cur_mode_dec), .home_pos(cur_home)
    );

    ssc_sweep_fsm #(.STEPS(STEPS)) u_fsm (
        .clk(clk), .rst(rst), .step(step), .spread_n(spread_n),
        .sel_mode(sel_mode), .sel_home(sel_home), .cur_home(cur_home),
        .cur_active(cur_active), .cur_mode(cur_mode),
        .nxt_active(nxt_active), .nxt_mode(nxt_mode), .nxt_pos(nxt_pos)
    );

    ssc_offset_map #(.STEPS(STEPS), .OFS_W(OFS_W)) u_map (
        .active(nxt_active), .mode(nxt_mode), .pos(nxt_pos), .ofs(nxt_ofs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_ppm <= '0;
            offset_vld <= 1'b0;
        end else begin
            offset_vld <= step;
            if (step) offset_ppm <= nxt_ofs;
        end
    end
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk #(
    parameter int STEPS = 64,
    parameter int OFS_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    spread_n,
    input logic                    step,
    input logic signed [OFS_W-1:0] offset_ppm,
    input logic                    offset_vld,
    input logic                    cur_active,
    input logic [1:0]              cur_mode
);
    localparam int MAXD = 10000 / STEPS + 1;

    p_rst_r1: assert property (@(posedge clk) rst |=> (offset_ppm == 0 && !offset_vld));

    p_off_r2: assert property (@(posedge clk) disable iff (rst)
        (step && spread_n) |=> (offset_ppm == 0 && !cur_active));

    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !cur_active |-> offset_ppm == 0);

    p_ctr_r3: assert property (@(posedge clk) disable iff (rst)
        (cur_active && cur_mode == 2'b01) |-> (offset_ppm <= 4500 && offset_ppm >= -4500));

    p_dn10_r4: assert property (@(posedge clk) disable iff (rst)
        (cur_active && cur_mode == 2'b10) |-> (offset_ppm <= 0 && offset_ppm >= -10000));

    p_dn05_r5: assert property (@(posedge clk) disable iff (rst)
        (cur_active && cur_mode == 2'b11) |-> (offset_ppm <= 0 && offset_ppm >= -5000));

    p_step_r7: assert property (@(posedge clk) disable iff (rst)
        (offset_vld && cur_active && $past(cur_active)) |->
        ((int'(offset_ppm) - int'($past(offset_ppm)) <= MAXD) &&
         (int'(offset_ppm) - int'($past(offset_ppm)) >= -MAXD)));

    p_chg_r9: assert property (@(posedge clk) disable iff (rst)
        (cur_active && $past(cur_active) && cur_mode != $past(cur_mode)) |-> offset_ppm == 0);

    p_vld_r10: assert property (@(posedge clk) disable iff (rst) step |=> offset_vld);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !step |=> (!offset_vld && $stable(offset_ppm)));
endmodule

bind ssc_profile_gen ssc_profile_chk #(.STEPS(STEPS), .OFS_W(OFS_W)) u_chk (
    .clk(clk), .rst(rst), .spread_n(spread_n), .step(step),
    .offset_ppm(offset_ppm), .offset_vld(offset_vld),
    .cur_active(cur_active), .cur_mode(cur_mode_bits)
);

// File: tb/sim_ssc_profile_gen.sv
module sim_ssc_profile_gen;
    localparam int CLK_PERIOD = 10;
    localparam int STEPS = 64;
    localparam int OFS_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spread_n = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic step = 1'b0;
    logic signed [OFS_W-1:0] offset_ppm;
    logic offset_vld;

    ssc_profile_gen #(.STEPS(STEPS), .OFS_W(OFS_W)) u0 (
        .clk(clk), .rst(rst), .spread_n(spread_n), .mode_sel(mode_sel),
        .step(step), .offset_ppm(offset_ppm), .offset_vld(offset_vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_q[$];
    string req_q[$];
    int seen_min = 0;
    int seen_max = 0;

    // reference model, built from the requirements
    bit m_act = 1'b0;
    int m_mode = 0;
    int m_pos = 0;
    bit m_dn = 1'b1;

    function automatic int home_of(int md);
        return (md == 1) ? STEPS / 2 : 0;
    endfunction

    function automatic int ofs_of(int md, int p);
        case (md)
            1: return 4500 - (9000 * p) / STEPS;
            2: return -((10000 * p) / STEPS);
            3: return -((5000 * p) / STEPS);
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_step(input bit en_n, input int s, output int e);
        if (en_n) begin
            m_act = 1'b0;
        end else if (!m_act) begin
            if (s != 0) begin
                m_act = 1'b1; m_mode = s; m_pos = home_of(s); m_dn = 1'b1;
            end
        end else begin
            if (m_dn) begin
                m_pos++;
                if (m_pos == STEPS) m_dn = 1'b0;
            end else begin
                m_pos--;
                if (m_pos == 0) m_dn = 1'b1;
            end
            if (m_pos == home_of(m_mode) && s != m_mode) begin
                if (s == 0) m_act = 1'b0;
                else begin
                    m_mode = s; m_pos = home_of(s); m_dn = 1'b1;
                end
            end
        end
        e = m_act ? ofs_of(m_mode, m_pos) : 0;
    endtask

    task automatic strobe(input bit en_n, input logic [1:0] s, input string req, input int gap);
        int e;
        spread_n = en_n;
        mode_sel = s;
        step = 1'b1;
        model_step(en_n, int'(s), e);
        exp_q.push_back(e);
        req_q.push_back(req);
        @(negedge clk);
        step = 1'b0;
        for (int i = 0; i < gap; i++) @(negedge clk);
    endtask

    task automatic run(input bit en_n, input logic [1:0] s, input string req, input int n);
        for (int i = 0; i < n; i++) strobe(en_n, s, req, i % 3);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: pops one expected word per valid pulse
    always @(negedge clk) begin
        if (!rst && offset_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected valid", 1, 0);
            end else begin
                automatic int e = exp_q.pop_front();
                automatic string r = req_q.pop_front();
                check(int'(offset_ppm) == e, r, int'(offset_ppm), e);
                if (int'(offset_ppm) < seen_min) seen_min = int'(offset_ppm);
                if (int'(offset_ppm) > seen_max) seen_max = int'(offset_ppm);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            report();
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        check(offset_ppm == 0, "R1 offset in reset", int'(offset_ppm), 0);
        check(offset_vld == 1'b0, "R1 valid in reset", int'(offset_vld), 0);
        rst = 1'b0;
        @(negedge clk);
        check(offset_ppm == 0 && !offset_vld, "R1 after release", int'(offset_ppm), 0);

        // disabled strobes
        run(1'b1, 2'b01, "R2 disabled", 3);
        repeat (5) @(negedge clk);
        check(offset_vld == 1'b0, "R10 no strobe no valid", int'(offset_vld), 0);

        // centre profile, full period and more
        seen_min = 0; seen_max = 0;
        run(1'b0, 2'b01, "R3 R7 R8 centre", 2 * STEPS + 4);
        check(seen_max == 4500, "R3 centre top", seen_max, 4500);
        check(seen_min == -4500, "R3 centre bottom", seen_min, -4500);
        held = int'(offset_ppm);
        repeat (6) @(negedge clk);
        check(int'(offset_ppm) == held, "R10 offset held", int'(offset_ppm), held);

        // select change in mid-sweep waits for nominal
        run(1'b0, 2'b10, "R9 deferred switch", 2 * STEPS);
        seen_min = 0; seen_max = 0;
        run(1'b0, 2'b10, "R4 R7 down 1pct", 2 * STEPS + 2);
        check(seen_min == -10000, "R4 down1 bottom", seen_min, -10000);
        check(seen_max == 0, "R4 down1 never above nominal", seen_max, 0);

        // disable, then 0.5 % down profile
        strobe(1'b1, 2'b11, "R2 stop", 1);
        seen_min = 0; seen_max = 0;
        run(1'b0, 2'b11, "R5 R8 down 0.5pct", 2 * STEPS + 2);
        check(seen_min == -5000, "R5 down05 bottom", seen_min, -5000);
        check(seen_max == 0, "R5 down05 top", seen_max, 0);

        // disable in mid-sweep, then restart
        run(1'b0, 2'b11, "R5 partial", 10);
        strobe(1'b1, 2'b11, "R2 mid-sweep stop", 2);
        check(offset_ppm == 0, "R2 zero after stop", int'(offset_ppm), 0);
        run(1'b0, 2'b10, "R8 restart", 3);

        // disable landing on a turnaround strobe
        run(1'b0, 2'b10, "R7 toward limit", STEPS - 3);
        strobe(1'b1, 2'b10, "R2 stop at limit", 1);
        run(1'b0, 2'b01, "R8 centre restart", 5);

        // select 00 while running, then while idle
        run(1'b0, 2'b00, "R9 switch to none", STEPS);
        check(offset_ppm == 0, "R9 stopped at nominal", int'(offset_ppm), 0);
        run(1'b0, 2'b00, "R6 none idle", 4);
        check(offset_ppm == 0, "R6 zero offset", int'(offset_ppm), 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 every strobe answered", exp_q.size(), 0);
        done = 1'b1;
        report();
    end
endmodule